// File: doc/BRIEF.md
# Streaming Dot-Product Engine

This block forms the dot product of two signed integer vectors that arrive one element pair at a time. Each accepted pair goes through a three-stage pipelined multiplier. Each product then goes into a three-stage adder ring. Every adder result loops back to the ring's input. As a result, the three ring stages hold three separate partial sums that rotate while products keep arriving. When the pair flagged as last has left the multiplier, a reduction step adds the three partial sums into one result. That result is presented for exactly one cycle.

Input ready stays high while a vector streams, so one pair can be accepted on every clock. From the cycle after the last pair is accepted until the result is presented, ready is held low. Operands are 16-bit signed, products are 32 bits and partial sums are 40 bits wide. The ring rotates only when a product arrives, so product number k always lands in partial sum k mod 3.

Top module: `dotp_engine`

## Requirements
- R1: After synchronous active-high reset, in_ready is 1, out_valid is 0 and out_result is 0.
- R2: While a vector streams, in_ready stays 1, so one operand pair is accepted on every clock edge at which in_valid is 1.
- R3: out_result equals the two's-complement sum of the signed products in_a*in_b over all pairs of the vector, kept to 40 bits.
- R4: If the last pair (in_last=1) is accepted at clock edge E, then in_ready is 0 from E until the edge E+4. At E+4 both out_valid and in_ready become 1.
- R5: out_valid is high for exactly one cycle per vector.
- R6: Vectors of length 1 and 2 give the correct sum, with the unused partial sums contributing zero.
- R7: Idle cycles (in_valid=0) between the pairs of a vector do not change the result.
- R8: in_valid, in_a, in_b and in_last have no effect while in_ready is 0.
- R9: Each vector starts from zero partial sums, so a result never includes terms from an earlier vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Engine can accept a pair |
| in_last | input | 1 | Marks the final pair of a vector |
| in_a | input | 16 | Signed operand A |
| in_b | input | 16 | Signed operand B |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 40 | Signed dot product |

## Verification
The bench covers vectors of length 1 and 2. If a design fed stale or uninitialised partial sums into the empty slots, the result would be wrong for these lengths. Idle gaps inside a vector catch a design that rotates the ring on empty cycles but mis-merges the slots. Junk pairs with the last flag set are driven while the engine is busy, to expose a design that lets them into the multiplier. A following short vector with small values exposes leftover partial sums. Extreme negative operands and a 300-element vector of maximum values check sign extension and 40-bit growth. Each vector's ready and valid timing is checked cycle by cycle, which catches any off-by-one in draining the multiplier.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    // Controller phases of one vector
    typedef enum logic [1:0] {
        PH_STREAM = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_MERGE  = 2'd2
    } dotp_phase_e;
endpackage

// File: rtl/dotp_mul_pipe.sv
module dotp_mul_pipe #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_fire,
    input  logic              in_last,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    output logic              prod_valid,
    output logic              prod_last,
    output logic [PROD_W-1:0] prod_data
);
    typedef struct packed {
        logic              s1_v;
        logic              s1_l;
        logic [OP_W-1:0]   s1_a;
        logic [OP_W-1:0]   s1_b;
        logic              s2_v;
        logic              s2_l;
        logic [PROD_W-1:0] s2_p;
        logic              s3_v;
        logic              s3_l;
        logic [PROD_W-1:0] s3_p;
    } mul_regs_t;

    mul_regs_t mul_d, mul_q;
    logic signed [PROD_W-1:0] ext_a, ext_b;

    always_comb begin
        mul_d = mul_q;
        ext_a = {{OP_W{mul_q.s1_a[OP_W-1]}}, mul_q.s1_a};
        ext_b = {{OP_W{mul_q.s1_b[OP_W-1]}}, mul_q.s1_b};
        // stage 1: operand capture
        mul_d.s1_v = in_fire;
        mul_d.s1_l = in_fire & in_last;
        if (in_fire) begin
            mul_d.s1_a = in_a;
            mul_d.s1_b = in_b;
        end
        // stage 2: partial product
        mul_d.s2_v = mul_q.s1_v;
        mul_d.s2_l = mul_q.s1_l;
        if (mul_q.s1_v) begin
            mul_d.s2_p = ext_a * ext_b;
        end
        // stage 3: product out
        mul_d.s3_v = mul_q.s2_v;
        mul_d.s3_l = mul_q.s2_l;
        if (mul_q.s2_v) begin
            mul_d.s3_p = mul_q.s2_p;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_q <= '0;
        end else begin
            mul_q <= mul_d;
        end
    end

    assign prod_valid = mul_q.s3_v;
    assign prod_last  = mul_q.s3_l;
    assign prod_data  = mul_q.s3_p;

    AST_MUL_DEPTH: assert property (@(posedge clk) disable iff (rst)
        prod_valid |-> $past(in_fire, 3)); // R2
endmodule

// File: rtl/dotp_acc_ring.sv
module dotp_acc_ring #(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40,
    localparam int EXT_W = ACC_W - PROD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_valid,
    input  logic [PROD_W-1:0] add_prod,
    input  logic              merge,
    output logic              res_valid,
    output logic [ACC_W-1:0]  res_data
);
    typedef struct packed {
        logic [ACC_W-1:0] slot1;
        logic [ACC_W-1:0] slot2;
        logic [ACC_W-1:0] slot3;
        logic             res_v;
        logic [ACC_W-1:0] res;
    } ring_regs_t;

    ring_regs_t ring_d, ring_q;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] slot_sum;

    always_comb begin
        ring_d   = ring_q;
        prod_ext = {{EXT_W{add_prod[PROD_W-1]}}, add_prod};
        slot_sum = ring_q.slot1 + ring_q.slot2 + ring_q.slot3;
        ring_d.res_v = 1'b0;
        if (merge) begin
            ring_d.res   = slot_sum;
            ring_d.res_v = 1'b1;
            ring_d.slot1 = '0;
            ring_d.slot2 = '0;
            ring_d.slot3 = '0;
        end else if (add_valid) begin
            // the oldest partial sum re-enters the adder with the new product
            ring_d.slot1 = ring_q.slot3 + prod_ext;
            ring_d.slot2 = ring_q.slot1;
            ring_d.slot3 = ring_q.slot2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign res_valid = ring_q.res_v;
    assign res_data  = ring_q.res;

    AST_RING_CONSERVES: assert property (@(posedge clk) disable iff (rst)
        (add_valid && !merge) |=> slot_sum == $past(slot_sum) + $past(prod_ext)); // R3
    AST_RING_CLEARED: assert property (@(posedge clk) disable iff (rst)
        merge |=> slot_sum == '0); // R9
endmodule

// File: rtl/dotp_engine.sv
module dotp_engine #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_last,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_result
);
    import dotp_pkg::*;

    typedef struct packed {
        dotp_phase_e phase;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;
    logic              fire;
    logic              merge;
    logic              pv, pl;
    logic [PROD_W-1:0] pd;

    always_comb begin
        ctl_d    = ctl_q;
        in_ready = (ctl_q.phase == PH_STREAM);
        fire     = in_valid & in_ready;
        merge    = (ctl_q.phase == PH_MERGE);
        case (ctl_q.phase)
            PH_STREAM: if (fire && in_last) ctl_d.phase = PH_DRAIN;
            PH_DRAIN:  if (pv && pl)        ctl_d.phase = PH_MERGE;
            PH_MERGE:                       ctl_d.phase = PH_STREAM;
            default:                        ctl_d.phase = PH_STREAM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{phase: PH_STREAM};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dotp_mul_pipe #(.OP_W(OP_W)) u_mul (
        .clk        (clk),
        .rst        (rst),
        .in_fire    (fire),
        .in_last    (in_last),
        .in_a       (in_a),
        .in_b       (in_b),
        .prod_valid (pv),
        .prod_last  (pl),
        .prod_data  (pd)
    );

    dotp_acc_ring #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .add_valid (pv),
        .add_prod  (pd),
        .merge     (merge),
        .res_valid (out_valid),
        .res_data  (out_result)
    );

    AST_BUSY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (fire && in_last) |=> !in_ready); // R4
    AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R5
    AST_NO_PROD_WHILE_MERGE: assert property (@(posedge clk) disable iff (rst)
        merge |-> !pv); // R8
endmodule

// File: tb/dotp_engine_bench.sv
module dotp_engine_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_last;
    logic [15:0] in_a, in_b;
    logic        out_valid;
    logic [39:0] out_result;
    int n_chk = 0;
    int n_bad = 0;
    logic signed [15:0] va [0:511];
    logic signed [15:0] vb [0:511];

    always #4 clk = ~clk;

    dotp_engine u_dotp_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_last(in_last), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one vector: stream, then watch the result window cycle by cycle
    task automatic run_vec(input int len, input int gap, input bit junk, input string req);
        longint exp = 0;
        int first_k = -1;
        bit rdy_stream_bad = 0, rdy_busy_bad = 0, pulse_bad = 0;
        logic [39:0] got = '0;
        for (int i = 0; i < len; i++) exp += longint'(va[i]) * longint'(vb[i]);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (!in_ready) rdy_stream_bad = 1;
            in_valid = 1'b1; in_a = va[i]; in_b = vb[i]; in_last = (i == len - 1);
            @(posedge clk);
            if (gap > 0 && i != len - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (out_valid) begin
                if (first_k < 0) begin first_k = k; got = out_result; end
                else pulse_bad = 1;
            end
            if (k < 5 && in_ready) rdy_busy_bad = 1;
            if (k == 5 && !in_ready) rdy_busy_bad = 1;
            if (junk && k < 5) begin
                in_valid = 1'b1; in_a = 16'h7fff; in_b = 16'h8000; in_last = k[0];
            end else begin
                in_valid = 1'b0; in_last = 1'b0;
            end
        end
        check(!rdy_stream_bad, "R2", "ready while streaming", rdy_stream_bad, 0);
        check(got == exp[39:0], req, "dot product", longint'($signed(got)), exp);
        check(first_k == 5, "R4", "result cycle after last", first_k, 5);
        check(!rdy_busy_bad, "R4", "ready low then back with result", rdy_busy_bad, 0);
        check(!pulse_bad, "R5", "single valid pulse", pulse_bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        check(out_result == '0, "R1", "result after reset", out_result, 0);

        // R6 length 1 and 2
        va[0] = -16'sd7; vb[0] = 16'sd9;
        run_vec(1, 0, 0, "R6");
        va[0] = 16'sd300; vb[0] = -16'sd11; va[1] = 16'sd25; vb[1] = 16'sd40;
        run_vec(2, 0, 0, "R6");

        // R3 mixed values, lengths 3 and 7
        for (int i = 0; i < 7; i++) begin
            va[i] = 16'((i * 4099 + 17) * 13);
            vb[i] = 16'((i * 2311 + 5) * 29);
        end
        run_vec(3, 0, 0, "R3");
        run_vec(7, 0, 0, "R3");

        // R3 extreme negative operands
        for (int i = 0; i < 5; i++) begin
            va[i] = 16'sh8000; vb[i] = (i % 2 == 0) ? 16'sh8000 : 16'sh7fff;
        end
        run_vec(5, 0, 0, "R3");

        // R3 growth past 32 bits over a long vector
        for (int i = 0; i < 300; i++) begin va[i] = 16'sh7fff; vb[i] = 16'sh7fff; end
        run_vec(300, 0, 0, "R3");

        // R9 short vector right after the large one
        va[0] = 16'sd2; vb[0] = 16'sd3; va[1] = -16'sd4; vb[1] = 16'sd5;
        run_vec(2, 0, 0, "R9");

        // R7 idle gaps inside a vector
        for (int i = 0; i < 8; i++) begin
            va[i] = 16'(i * 1000 - 3500); vb[i] = 16'(77 - i * 31);
        end
        run_vec(8, 2, 0, "R7");
        run_vec(8, 1, 0, "R7");

        // R8 junk pairs with last flag while busy, then a fresh vector
        va[0] = 16'sd10; vb[0] = 16'sd10; va[1] = 16'sd1; vb[1] = -16'sd1;
        va[2] = 16'sd5;  vb[2] = 16'sd6;
        run_vec(3, 0, 1, "R8");
        va[0] = 16'sd123; vb[0] = -16'sd2;
        run_vec(1, 0, 0, "R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule